// File: doc/BRIEF.md
# Aliased Subsystem Address Decoder

This block decodes a 32-bit bus address for a subsystem that maps its memory and devices twice: once in a secure 256 MB window and once in a non-secure one. On each valid request it produces, one clock later, a one-hot target select and an address offset inside the chosen target. The targets are banked SRAM, the register pages of the per-bank memory protection controllers, the security controller, the timers, the system information and control pages, the watchdogs, and an external board port that takes everything else.

Three whole windows mirror the window below them: region 1 mirrors region 0, region 3 mirrors region 2 and region 5 mirrors region 4. Some control pages exist only in region 5 and take priority over the mirror there. Accesses through a mirror present the same offset as the direct access. The number of SRAM banks and the bank address width are parameters. An illegal combination of these parameters stops elaboration. Bus handshakes, the memories and the access-permission checks sit outside this block.

Top module: `alias_addr_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dec_valid` is 0, `dec_sel` is all zeros and `dec_offset` is 0.
- R2: The decode of a request sampled with `req_valid` high appears on the outputs at the next rising clock edge. After a cycle with `req_valid` low, `dec_valid` is 0, `dec_sel` is 0 and `dec_offset` is 0.
- R3: When `dec_valid` is 1, exactly one bit of `dec_sel` is set. Bit order: 0 external port, 1 security controller secure page, 2 security controller non-secure page, 3 timer A, 4 timer B, 5 dual timer, 6 slow-clock timer, 7 system information, 8 system control, 9 slow-clock watchdog, 10 non-secure watchdog, 11 secure watchdog, 12+i SRAM bank i, 12+NUM_BANKS+i protection-controller register page of bank i.
- R4: An address whose top nibble is 1 or 3 decodes exactly like the same address with bit 28 cleared. The target and the offset are both identical.
- R5: An address whose top nibble is 5 decodes like the same address with bit 28 cleared, unless it falls in a page that exists only in region 5. Those pages are the secure security-controller page, system control, the slow-clock watchdog, the secure watchdog and the protection-controller pages, and they take priority over the mirror. These pages are not reachable through region 4.
- R6: SRAM bank i covers 2^BANK_AW bytes starting at 0x20000000 + i * 2^BANK_AW. The offset is the address minus the bank start. Addresses in region 2 beyond the last bank go to the external port.
- R7: The protection-controller register page of bank i is the 4 KB page at 0x50083000 + i * 0x1000, with the offset equal to the low 12 address bits. The address 0x40083000 does not reach it.
- R8: The security controller decodes its secure page at 0x50080000 and its non-secure page at 0x40080000. Both are 4 KB, and each has the low 12 address bits as its offset.
- R9: The following are 4 KB pages with the low 12 address bits as offset: timer A 0x40000000, timer B 0x40001000, dual timer 0x40002000, slow-clock timer 0x4002F000, system information 0x40020000, system control 0x50021000.
- R10: The watchdog pages are 4 KB, with the low 12 address bits as offset: slow-clock watchdog 0x5002E000, non-secure watchdog 0x40081000, secure watchdog 0x50081000.
- R11: An address matching no device selects the external port. Its offset is the address after mirror folding, which is the raw address for top nibbles other than 1, 3 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe for the address on `req_addr` |
| req_addr | input | 32 | Bus address to decode |
| dec_valid | output | 1 | Registered decode result is valid |
| dec_sel | output | 12+2*NUM_BANKS | One-hot target select, bit order per R3 |
| dec_offset | output | 32 | Offset inside the selected target |

## Verification
The bench builds the decoder with four banks and a bank address width of 12. With these values every SRAM bank edge, the first address past the last bank and all four protection-controller pages fall within a few directed addresses. Mirrored addresses in regions 1, 3 and 5 are driven next to their direct twins. The region-5 override of the non-secure security-controller and watchdog pages is driven against the plain mirror. A random stream biased toward page bases, with idle gaps, is compared every clock against a priority-ordered reference decode.

// File: rtl/adec_pkg.sv
package adec_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned PAGE_LG = 12;
  localparam int unsigned N_FIXED = 12;

  localparam int unsigned IDX_EXT      = 0;
  localparam int unsigned IDX_SEC_S    = 1;
  localparam int unsigned IDX_SEC_NS   = 2;
  localparam int unsigned IDX_TMR_A    = 3;
  localparam int unsigned IDX_TMR_B    = 4;
  localparam int unsigned IDX_DUAL     = 5;
  localparam int unsigned IDX_SLOW_TMR = 6;
  localparam int unsigned IDX_SYSINFO  = 7;
  localparam int unsigned IDX_SYSCTL   = 8;
  localparam int unsigned IDX_WD_SLOW  = 9;
  localparam int unsigned IDX_WD_NS    = 10;
  localparam int unsigned IDX_WD_S     = 11;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t SRAM_BASE  = 32'h2000_0000;
  localparam addr_t PCREG_BASE = 32'h5008_3000;

  // Mirror windows 1, 3 and 5 fold onto 0, 2 and 4 by clearing bit 28.
  function automatic addr_t fold_mirror(addr_t a);
    addr_t f;
    f = a;
    if (a[31:28] == 4'h1 || a[31:28] == 4'h3 || a[31:28] == 4'h5) f[28] = 1'b0;
    return f;
  endfunction

  function automatic addr_t fixed_base(int unsigned k);
    case (k)
      IDX_SEC_S:    return 32'h5008_0000;
      IDX_SEC_NS:   return 32'h4008_0000;
      IDX_TMR_A:    return 32'h4000_0000;
      IDX_TMR_B:    return 32'h4000_1000;
      IDX_DUAL:     return 32'h4000_2000;
      IDX_SLOW_TMR: return 32'h4002_F000;
      IDX_SYSINFO:  return 32'h4002_0000;
      IDX_SYSCTL:   return 32'h5002_1000;
      IDX_WD_SLOW:  return 32'h5002_E000;
      IDX_WD_NS:    return 32'h4008_1000;
      IDX_WD_S:     return 32'h5008_1000;
      default:      return '0;
    endcase
  endfunction

  // Pages that only exist in the high mirror window and override it.
  function automatic logic fixed_hi_only(int unsigned k);
    return (k == IDX_SEC_S) || (k == IDX_SYSCTL) || (k == IDX_WD_SLOW) || (k == IDX_WD_S);
  endfunction

  function automatic logic same_page(addr_t a, addr_t base);
    return a[ADDR_W-1:PAGE_LG] == base[ADDR_W-1:PAGE_LG];
  endfunction

  function automatic addr_t keep_low(addr_t a, int unsigned lg);
    return a & ((addr_t'(1) << lg) - addr_t'(1));
  endfunction

  function automatic addr_t bank_base(int unsigned i, int unsigned lg);
    return SRAM_BASE + (addr_t'(i) << lg);
  endfunction

  function automatic addr_t pcreg_base(int unsigned i);
    return PCREG_BASE + (addr_t'(i) << PAGE_LG);
  endfunction
endpackage

// File: rtl/adec_fixed_match.sv
module adec_fixed_match
  import adec_pkg::*;
(
  input  addr_t              raw_addr,
  input  addr_t              fold_addr,
  output logic [N_FIXED-1:0] hi_hit,
  output logic [N_FIXED-1:0] lo_hit
);
  assign hi_hit[IDX_EXT] = 1'b0;
  assign lo_hit[IDX_EXT] = 1'b0;

  for (genvar k = 1; k < N_FIXED; k++) begin : g_dev
    localparam addr_t BASE = fixed_base(k);
    if (fixed_hi_only(k)) begin : g_hi
      assign hi_hit[k] = same_page(raw_addr, BASE);
      assign lo_hit[k] = 1'b0;
    end else begin : g_lo
      assign hi_hit[k] = 1'b0;
      assign lo_hit[k] = same_page(fold_addr, BASE);
    end
  end
endmodule

// File: rtl/adec_bank_match.sv
module adec_bank_match
  import adec_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_AW   = 15
) (
  input  addr_t                raw_addr,
  input  addr_t                fold_addr,
  output logic [NUM_BANKS-1:0] sram_hit,
  output logic [NUM_BANKS-1:0] pc_hit
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    localparam addr_t SBASE = bank_base(i, BANK_AW);
    localparam addr_t PBASE = pcreg_base(i);
    assign sram_hit[i] = (fold_addr[ADDR_W-1:BANK_AW] == SBASE[ADDR_W-1:BANK_AW]);
    assign pc_hit[i]   = same_page(raw_addr, PBASE);
  end
endmodule

// File: rtl/alias_addr_decoder.sv
module alias_addr_decoder
  import adec_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_AW   = 15
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic [31:0]                     req_addr,
  output logic                            dec_valid,
  output logic [N_FIXED+2*NUM_BANKS-1:0]  dec_sel,
  output logic [31:0]                     dec_offset
);
  localparam int unsigned NT      = N_FIXED + 2 * NUM_BANKS;
  localparam int unsigned SRAM_LO = N_FIXED;
  localparam int unsigned PC_LO   = N_FIXED + NUM_BANKS;
  localparam int unsigned BANK_LG = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 0;

  if ((32'd1 << BANK_LG) != NUM_BANKS || BANK_AW < 1 || BANK_AW > 24 - BANK_LG) begin : g_bad_cfg
    $error("alias_addr_decoder: bank count must be a power of two and BANK_AW within 1..24-log2(banks)");
  end

  function automatic logic [NT-1:0] mask_hi();
    logic [NT-1:0] m;
    m = '0;
    for (int k = 0; k < N_FIXED; k++) if (fixed_hi_only(k)) m[k] = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++) m[PC_LO+b] = 1'b1;
    return m;
  endfunction

  function automatic logic [NT-1:0] mask_sram();
    logic [NT-1:0] m;
    m = '0;
    for (int b = 0; b < NUM_BANKS; b++) m[SRAM_LO+b] = 1'b1;
    return m;
  endfunction

  localparam logic [NT-1:0] HI_MASK   = mask_hi();
  localparam logic [NT-1:0] SRAM_MASK = mask_sram();
  localparam logic [NT-1:0] PAGE_MASK = ~(SRAM_MASK | NT'(1));

  addr_t                folded;
  logic [N_FIXED-1:0]   fixed_hi, fixed_lo;
  logic [NUM_BANKS-1:0] sram_hit, pc_hit;
  logic [NT-1:0]        hi_vec, lo_vec, sel_next;
  logic                 hi_any, lo_any, sram_any;
  addr_t                off_next;

  assign folded = fold_mirror(req_addr);

  adec_fixed_match u_fixed (
    .raw_addr  (req_addr),
    .fold_addr (folded),
    .hi_hit    (fixed_hi),
    .lo_hit    (fixed_lo)
  );

  adec_bank_match #(.NUM_BANKS(NUM_BANKS), .BANK_AW(BANK_AW)) u_banks (
    .raw_addr  (req_addr),
    .fold_addr (folded),
    .sram_hit  (sram_hit),
    .pc_hit    (pc_hit)
  );

  assign hi_vec   = {pc_hit, {NUM_BANKS{1'b0}}, fixed_hi};
  assign lo_vec   = {{NUM_BANKS{1'b0}}, sram_hit, fixed_lo};
  assign hi_any   = |hi_vec;
  assign lo_any   = |lo_vec;
  assign sram_any = |sram_hit;

  // Priority: region-5-only pages, then folded devices/SRAM, then external port.
  always_comb begin
    if (hi_any) begin
      sel_next = hi_vec;
      off_next = keep_low(req_addr, PAGE_LG);
    end else if (sram_any) begin
      sel_next = lo_vec;
      off_next = keep_low(folded, BANK_AW);
    end else if (lo_any) begin
      sel_next = lo_vec;
      off_next = keep_low(folded, PAGE_LG);
    end else begin
      sel_next = NT'(1);
      off_next = folded;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_sel    <= '0;
      dec_offset <= '0;
    end else if (req_valid) begin
      dec_valid  <= 1'b1;
      dec_sel    <= sel_next;
      dec_offset <= off_next;
    end else begin
      dec_valid  <= 1'b0;
      dec_sel    <= '0;
      dec_offset <= '0;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $countones(dec_sel) == 1); // R3
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (dec_sel == '0 && dec_offset == '0)); // R2
  AST_HI_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && |(dec_sel & HI_MASK)) |-> $past(req_addr[31:28]) == 4'h5); // R5
  AST_SRAM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && |(dec_sel & SRAM_MASK)) |-> dec_offset < (32'd1 << BANK_AW)); // R6
  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && |(dec_sel & PAGE_MASK)) |-> dec_offset < 32'h1000); // R9
  AST_HI_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hi_vec) && $onehot0(lo_vec)); // R3
endmodule

// File: tb/alias_addr_decoder_test.sv
module alias_addr_decoder_test;
  localparam int NB = 4;
  localparam int AW = 12;
  localparam int NT = 12 + 2 * NB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [31:0]   req_addr = '0;
  logic          dec_valid;
  logic [NT-1:0] dec_sel;
  logic [31:0]   dec_offset;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  // Pending expectation for the outputs after the next rising edge.
  bit          pend_valid = 0;
  int          pend_idx = 0;
  logic [31:0] pend_off = '0;
  logic [31:0] pend_addr = '0;
  string       pend_tag = "R2";

  always #10 clk = ~clk;

  alias_addr_decoder #(.NUM_BANKS(NB), .BANK_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .dec_valid(dec_valid), .dec_sel(dec_sel), .dec_offset(dec_offset)
  );

  // Reference: ordered list of rules, first match wins.
  task automatic ref_decode(input logic [31:0] a, output int idx, output logic [31:0] off);
    int r;
    logic [31:0] m;
    r = int'(a[31:28]);
    m = (r == 1 || r == 3 || r == 5) ? a - 32'h1000_0000 : a;
    idx = -1;
    off = {20'h0, a[11:0]};
    if (r == 5) begin
      case (a[31:12])
        20'h50080: idx = 1;
        20'h50021: idx = 8;
        20'h5002E: idx = 9;
        20'h50081: idx = 11;
        default: ;
      endcase
      for (int b = 0; b < NB; b++)
        if (a[31:12] == 20'h50083 + 20'(b)) idx = 12 + NB + b;
    end
    if (idx < 0) begin
      off = {20'h0, m[11:0]};
      case (m[31:12])
        20'h40080: idx = 2;
        20'h40000: idx = 3;
        20'h40001: idx = 4;
        20'h40002: idx = 5;
        20'h4002F: idx = 6;
        20'h40020: idx = 7;
        20'h40081: idx = 10;
        default: ;
      endcase
    end
    if (idx < 0) begin
      if (m >= 32'h2000_0000 && m < 32'h2000_0000 + NB * (1 << AW)) begin
        idx = 12 + int'((m - 32'h2000_0000) >> AW);
        off = (m - 32'h2000_0000) % (1 << AW);
      end else begin
        idx = 0;
        off = m;
      end
    end
  endtask

  task automatic compare();
    logic [NT-1:0] es;
    checks++;
    es = pend_valid ? (NT'(1) << pend_idx) : '0;
    if (dec_valid !== pend_valid || dec_sel !== es ||
        dec_offset !== (pend_valid ? pend_off : 32'h0)) begin
      bad++;
      $display("FAIL %s addr=%h valid act=%0b exp=%0b sel act=%h exp=%h off act=%h exp=%h",
               pend_tag, pend_addr, dec_valid, pend_valid, dec_sel, es, dec_offset,
               pend_valid ? pend_off : 32'h0);
    end
  endtask

  // Compare at the falling edge, then drive the next request.
  task automatic step(input bit v, input logic [31:0] a, input string tag);
    int i;
    logic [31:0] o;
    @(negedge clk);
    compare();
    req_valid = v;
    req_addr = a;
    ref_decode(a, i, o);
    pend_valid = v;
    pend_idx = i;
    pend_off = o;
    pend_addr = a;
    pend_tag = v ? tag : "R2";
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held in reset
    pend_tag = "R1";
    compare();
    req_valid = 1'b1;
    req_addr = 32'h4000_0000;
    @(negedge clk);
    compare();  // R1: request during reset has no effect
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    compare();  // R1: first cycle after release

    // R11 external port, R4 low mirrors
    step(1, 32'h0000_1234, "R11");
    step(1, 32'h1000_1234, "R4");
    step(1, 32'h7000_0010, "R11");
    step(1, 32'hF000_0000, "R11");
    // R6 SRAM banks and edges
    step(1, 32'h2000_0000, "R6");
    step(1, 32'h2000_0FFF, "R6");
    step(1, 32'h2000_1000, "R6");
    step(1, 32'h2000_3FFF, "R6");
    step(1, 32'h2000_4000, "R6");
    step(1, 32'h3000_2004, "R4");
    step(1, 32'h3000_4000, "R4");
    // R7 protection-controller pages
    step(1, 32'h5008_3000, "R7");
    step(1, 32'h5008_6FFC, "R7");
    step(1, 32'h5008_7000, "R7");
    step(1, 32'h4008_3000, "R7");
    // R8 security controller
    step(1, 32'h4008_0010, "R8");
    step(1, 32'h5008_0010, "R8");
    // R9 peripherals
    step(1, 32'h4000_0004, "R9");
    step(1, 32'h4000_1008, "R9");
    step(1, 32'h4000_2FFC, "R9");
    step(1, 32'h4002_F000, "R9");
    step(1, 32'h4002_0FF0, "R9");
    step(1, 32'h5002_1000, "R9");
    // R5 high mirror and its overrides
    step(1, 32'h5000_0004, "R5");
    step(1, 32'h5002_F010, "R5");
    step(1, 32'h4002_1000, "R5");
    step(1, 32'h4002_E000, "R5");
    step(1, 32'h5000_0000, "R5");
    // R10 watchdogs
    step(1, 32'h5002_E000, "R10");
    step(1, 32'h4008_1000, "R10");
    step(1, 32'h5008_1000, "R10");
    // R2 idle gap and back-to-back
    step(0, 32'h4000_0000, "R2");
    step(0, 32'h5008_3000, "R2");
    step(1, 32'h2000_2000, "R2");
    step(1, 32'h4008_1FFF, "R2");

    // R3 random stream biased to page bases
    for (int n = 0; n < 400; n++) begin
      logic [31:0] base;
      logic [31:0] a;
      case ($urandom_range(0, 7))
        0: base = 32'h4000_0000;
        1: base = 32'h4002_0000;
        2: base = 32'h4008_0000;
        3: base = 32'h5008_0000;
        4: base = 32'h5002_0000;
        5: base = 32'h2000_0000;
        6: base = 32'h3000_0000;
        default: base = $urandom;
      endcase
      a = base + ($urandom & 32'h0000_FFFF);
      step(($urandom_range(0, 4) != 0), a, "R3");
    end
    step(0, 32'h0, "R2");
    @(negedge clk);
    compare();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule